// File: doc/BRIEF.md
# Fully Associative Tag-Match Memory

This block is a small content-addressed store. Every line keeps one full address as its tag, one data word and a valid bit. The incoming address goes to all lines at once, and each line compares it with its own tag. A matching line raises its word line. The word lines then select the data to put on the output, so no address decoder is needed. A single miss output goes high when no valid line matches. The read path is purely combinational.

A write while the address hits replaces the data of the matching line. A write while the address misses allocates a line: the address becomes that line's tag and the data goes with it. The line is the one chosen by an internal victim pointer. The pointer moves on by one only after an allocating write and wraps at the last line. Lines are therefore evicted in the order they were filled.

The write path decides among three actions, held in an enumerated type. ACT_NONE applies when the write strobe is low. ACT_UPDATE applies to a write that hits. ACT_ALLOCATE applies to a write that misses. The transition into ACT_ALLOCATE is the only one that advances the pointer.

Top module: `assoc_mem`

## Requirements
- R1: After reset every line is invalid, so miss is 1 and rd_data is 0 for any address until the first write.
- R2: miss is 1 exactly when no valid line holds a tag equal to addr_in. It follows addr_in combinationally in the same cycle.
- R3: On a hit, rd_data equals the data word of the matching line, combinationally.
- R4: While miss is 1, rd_data is all zeros.
- R5: A write (wr_en=1 at a rising edge) to an address that hits replaces only that line's data. It does not move the victim pointer.
- R6: A write to an address that misses stores addr_in as the tag and wr_data as the data in the line at the victim pointer, marks it valid, and evicts whatever that line held.
- R7: The victim pointer starts at line 0, advances by one only on a missing write, and wraps from line DEPTH-1 to line 0. This gives first-in-first-out eviction.
- R8: With wr_en=0 a rising edge changes no line's tag, data or valid bit.
- R9: At most one line matches any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | Lookup and write address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Data to store |
| rd_data | output | DATA_W | Data of the matching line, zero on miss |
| miss | output | 1 | High when no valid line matches addr_in |

## Verification
The hardest case to reach is a write that hits after the memory has filled and wrapped. That write must leave the victim pointer alone, so the next allocation still evicts the oldest line and not the one just updated. A directed sequence fills every line and rewrites one of the lines. It then allocates new addresses and probes which old address vanished. Random traffic follows, drawn from a small address pool that is larger than the depth, so hits, updates and repeated wrap-around evictions all occur often.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_UPDATE   = 2'd1,
        ACT_ALLOCATE = 2'd2
    } wr_act_e;

endpackage

// File: rtl/assoc_line.sv
module assoc_line #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_all,
    input  logic              load_data,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wr_data,
    output logic              match,
    output logic [DATA_W-1:0] data_q
);

    logic              valid_q;
    logic [ADDR_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (load_all) begin
            valid_q <= 1'b1;
            tag_q   <= addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_all || load_data) begin
            data_q <= wr_data;
        end
    end

    always_comb begin
        match = valid_q && (tag_q == addr_in);
    end

    // R8
    line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_all && !load_data) |=> ($stable(tag_q) && $stable(data_q) && $stable(valid_q)));

    // R6
    line_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_all |=> (valid_q && tag_q == $past(addr_in) && data_q == $past(wr_data)));

endmodule

// File: rtl/assoc_victim_ptr.sv
module assoc_victim_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr_q
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr_q == LAST) |=> (ptr_q == '0));

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/assoc_hit_mux.sv
module assoc_hit_mux #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic [DEPTH-1:0]             word_line,
    input  logic [DEPTH-1:0][DATA_W-1:0] line_data,
    output logic                         any_hit,
    output logic [DATA_W-1:0]            rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_data = rd_data | (line_data[i] & {DATA_W{word_line[i]}});
        end
        any_hit = |word_line;
    end

    // R9
    always_comb begin
        one_line_chk: assert ($onehot0(word_line) || $isunknown(word_line));
    end

endmodule

// File: rtl/assoc_mem.sv
module assoc_mem
    import assoc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              miss
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]             word_line;
    logic [DEPTH-1:0][DATA_W-1:0] line_data;
    logic                         any_hit;
    logic [IDX_W-1:0]             victim;
    wr_act_e                      act;

    always_comb begin
        unique case ({wr_en, any_hit})
            2'b11:   act = ACT_UPDATE;
            2'b10:   act = ACT_ALLOCATE;
            default: act = ACT_NONE;
        endcase
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_line
            logic sel_alloc;
            logic sel_update;
            always_comb begin
                sel_alloc  = (act == ACT_ALLOCATE) && (victim == IDX_W'(g));
                sel_update = (act == ACT_UPDATE) && word_line[g];
            end
            assoc_line #(
                .ADDR_W(ADDR_W),
                .DATA_W(DATA_W)
            ) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_all (sel_alloc),
                .load_data(sel_update),
                .addr_in  (addr_in),
                .wr_data  (wr_data),
                .match    (word_line[g]),
                .data_q   (line_data[g])
            );
        end
    endgenerate

    assoc_victim_ptr #(
        .DEPTH(DEPTH)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(act == ACT_ALLOCATE),
        .ptr_q  (victim)
    );

    assoc_hit_mux #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_mux (
        .word_line(word_line),
        .line_data(line_data),
        .any_hit  (any_hit),
        .rd_data  (rd_data)
    );

    always_comb begin
        miss = !any_hit;
    end

    // R4
    zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (rd_data == '0));

    // R6
    alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && miss) |=> ((addr_in != $past(addr_in)) || (!miss && rd_data == $past(wr_data))));

    // R5
    update_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !miss) |=> ((addr_in != $past(addr_in)) || (!miss && rd_data == $past(wr_data))));

    // R8
    read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !miss) |=> ((addr_in != $past(addr_in)) || (!miss && rd_data == $past(rd_data))));

endmodule

// File: tb/tb_assoc_mem.sv
module tb_assoc_mem;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_in;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              miss;

    int n_checks;
    int n_fails;

    logic [ADDR_W-1:0] m_tag   [DEPTH];
    logic [DATA_W-1:0] m_data  [DEPTH];
    logic              m_valid [DEPTH];
    int                m_ptr;

    assoc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .miss(miss)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int model_find(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_valid[i] && m_tag[i] == a) return i;
        end
        return -1;
    endfunction

    function automatic logic [DATA_W-1:0] model_data(input logic [ADDR_W-1:0] a);
        int k;
        k = model_find(a);
        return (k < 0) ? '0 : m_data[k];
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] exp_d, input logic exp_m);
        n_checks++;
        if (rd_data !== exp_d || miss !== exp_m) begin
            n_fails++;
            $display("FAIL %s addr=%h got data=%h miss=%b expected data=%h miss=%b",
                     req, addr_in, rd_data, miss, exp_d, exp_m);
        end
    endtask

    // drive at negedge, check combinational outputs, model the edge
    task automatic op(input string req, input logic [ADDR_W-1:0] a,
                      input logic w, input logic [DATA_W-1:0] d);
        int k;
        @(negedge clk);
        addr_in = a;
        wr_en   = w;
        wr_data = d;
        #2;
        k = model_find(a);
        check(req, model_data(a), (k < 0));
        if (w) begin
            if (k >= 0) begin
                m_data[k] = d;
            end else begin
                m_tag[m_ptr]   = a;
                m_data[m_ptr]  = d;
                m_valid[m_ptr] = 1'b1;
                m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [ADDR_W-1:0] pool [24];
        n_checks = 0;
        n_fails  = 0;
        seed = $urandom(32'h5eed_0042);
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
            m_data[i]  = '0;
        end
        m_ptr   = 0;
        addr_in = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        rst_n   = 1'b0;
        for (int i = 0; i < 24; i++) pool[i] = ADDR_W'(16'h1000 + i * 16'h0111);

        // R1: outputs while held in reset and just after release
        repeat (2) @(posedge clk);
        #3;
        addr_in = 16'h0000;
        #1;
        check("R1", '0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) op("R1", pool[i], 1'b0, 16'hffff);

        // R8: reads only, then still empty
        op("R8", pool[0], 1'b0, 16'h1234);
        op("R8", pool[0], 1'b0, 16'h0);

        // R6 / R7: fill all lines in order
        for (int i = 0; i < DEPTH; i++) op("R6", pool[i], 1'b1, DATA_W'(16'ha000 + i));
        for (int i = 0; i < DEPTH; i++) op("R3", pool[i], 1'b0, '0);
        op("R4", pool[DEPTH], 1'b0, '0);

        // R5: rewrite line 0's address; pointer must stay at line 0
        op("R5", pool[0], 1'b1, 16'hbeef);
        op("R5", pool[0], 1'b0, '0);
        // R7: wrap, first allocation evicts the oldest (pool[0])
        op("R7", pool[DEPTH], 1'b1, 16'hc001);
        op("R7", pool[0], 1'b0, '0);
        op("R7", pool[1], 1'b0, '0);
        op("R7", pool[DEPTH + 1], 1'b1, 16'hc002);
        op("R7", pool[1], 1'b0, '0);
        op("R9", pool[DEPTH], 1'b0, '0);
        // R2: address one bit away from a stored tag
        op("R2", pool[DEPTH] ^ 16'h0001, 1'b0, '0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom();
            op((r[3:0] < 6) ? "R6" : "R2", pool[r % 24], (r[7:4] < 6), DATA_W'($urandom()));
        end

        // R8: random reads leave every stored line intact
        for (int i = 0; i < 24; i++) op("R8", pool[i], 1'b0, '0);

        // R1: reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) op("R1", pool[i], 1'b0, '0);
        op("R7", pool[5], 1'b1, 16'h5555);
        op("R7", pool[5], 1'b0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule